// File: doc/BRIEF.md
# Timed Credit-Return FIFO Channel

This block models a point-to-point target link as one flow-controlled queue. A sender pushes words through an enqueue port guarded by a ready flag. A receiver pops them through a dequeue port with its own ready flag. Each word spends an exact, configurable number of cycles in a forward delay line before the receiver can see it. Each dequeue sends a credit home through a separate reverse delay line, and that line has its own configurable length.

The sender's ready flag is a credit counter. The counter starts at the buffer depth and is the only gate on enqueue. Because the credit loop and the storage are the same structure, there is one queue and not two credit loops in series. With depth equal to the sum of the two latencies, a word can be accepted every cycle without limit. A smaller depth is legal and caps the rate at depth over the round trip.

Top module: `timed_credit_fifo`

## Requirements
- R1: After reset, `enq_rdy` is 1 (all DEPTH credits are held by the sender) and `deq_rdy` is 0.
- R2: A word accepted in cycle c (`enq`=1 with `enq_rdy`=1) first appears as `deq_rdy`=1 with that word on `deq_data` in cycle c+FWD_LAT, and not in any earlier cycle.
- R3: When no credits remain, a pop in cycle d raises `enq_rdy` in cycle d+REV_LAT, and not in cycle d+REV_LAT-1.
- R4: With no pops, exactly DEPTH words are accepted, and then `enq_rdy` drops to 0.
- R5: `enq`=1 while `enq_rdy`=0 is ignored: no word is delivered and no credit is spent.
- R6: Words leave in the order they were accepted, and none are lost or duplicated.
- R7: `deq`=1 while `deq_rdy`=0 is ignored and does not disturb later words.
- R8: An accept and a credit return in the same cycle leave the credit count unchanged. With DEPTH = FWD_LAT+REV_LAT and both sides always willing, `enq_rdy` therefore never drops in steady state.
- R9: In steady state the accept rate is min(1, DEPTH/(FWD_LAT+REV_LAT)) words per cycle.
- R10: The buffer never receives an arriving word while it holds DEPTH words and no pop occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq | input | 1 | Sender requests to push a word |
| enq_data | input | WIDTH | Word to push |
| enq_rdy | output | 1 | Sender holds at least one credit |
| deq | input | 1 | Receiver requests to pop a word |
| deq_data | output | WIDTH | Oldest word that has finished its forward delay |
| deq_rdy | output | 1 | At least one word is visible to the receiver |

## Verification
The bench builds two copies with forward latency 3 and reverse latency 2. The main copy has depth 5, which equals the round trip. That reaches the full-rate regime, where an accept and a returning credit coincide every cycle, and it allows the exact latency and exhaustion cycles to be measured. The second copy has depth 3, below the round trip, and runs the same stream. That shows the credit-limited rate of 3 words every 5 cycles and checks that ordering holds when the sender is throttled.

// File: rtl/timed_credit_fifo.sv
module timed_credit_fifo #(
  parameter int WIDTH   = 8,
  parameter int FWD_LAT = 3,
  parameter int REV_LAT = 2,
  parameter int DEPTH   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq,
  input  logic [WIDTH-1:0] enq_data,
  output logic             enq_rdy,
  input  logic             deq,
  output logic [WIDTH-1:0] deq_data,
  output logic             deq_rdy
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]    credits, count;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [WIDTH-1:0] mem [DEPTH];
  logic             enq_fire, deq_fire, arr_v, ret_v;
  logic [WIDTH-1:0] arr_d;
  int               fwd_cnt, rev_cnt;

  assign enq_rdy  = credits != '0;
  assign deq_rdy  = count != '0;
  assign enq_fire = enq & enq_rdy;
  assign deq_fire = deq & deq_rdy;
  assign deq_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    if (FWD_LAT == 1) begin : g_fwd_direct
      assign arr_v   = enq_fire;
      assign arr_d   = enq_data;
      assign fwd_cnt = 0;
    end else begin : g_fwd_pipe
      localparam int FS = FWD_LAT - 1;
      logic [FS-1:0]    v;
      logic [WIDTH-1:0] d [FS];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v <= '0;
        else begin
          v[0] <= enq_fire;
          for (int i = 1; i < FS; i++) v[i] <= v[i-1];
        end
      end
      always_ff @(posedge clk) begin
        d[0] <= enq_data;
        for (int i = 1; i < FS; i++) d[i] <= d[i-1];
      end
      assign arr_v   = v[FS-1];
      assign arr_d   = d[FS-1];
      assign fwd_cnt = $countones(v);
    end

    if (REV_LAT == 1) begin : g_rev_direct
      assign ret_v   = deq_fire;
      assign rev_cnt = 0;
    end else begin : g_rev_pipe
      localparam int RS = REV_LAT - 1;
      logic [RS-1:0] c;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c <= '0;
        else begin
          c[0] <= deq_fire;
          for (int i = 1; i < RS; i++) c[i] <= c[i-1];
        end
      end
      assign ret_v   = c[RS-1];
      assign rev_cnt = $countones(c);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credits <= CW'(DEPTH);
    else if (enq_fire != ret_v) credits <= enq_fire ? credits - 1'b1 : credits + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (arr_v) mem[wr_ptr] <= arr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (arr_v)    wr_ptr <= bump(wr_ptr);
      if (deq_fire) rd_ptr <= bump(rd_ptr);
      if (arr_v != deq_fire) count <= arr_v ? count + 1'b1 : count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_v && !deq_fire) |-> (count != CW'(DEPTH))); // R10
  AST_TOKEN_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(credits) + fwd_cnt + int'(count) + rev_cnt) == DEPTH); // R4
  AST_ENQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (enq && !enq_rdy && !ret_v) |=> (credits == $past(credits))); // R5
  AST_DEQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && !deq_rdy && !arr_v) |=> (count == $past(count) && rd_ptr == $past(rd_ptr))); // R7
  AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_fire && ret_v) |=> $stable(credits)); // R8
endmodule

// File: tb/test_timed_credit_fifo.sv
`timescale 1ns/1ps
module test_timed_credit_fifo;
  localparam int W = 8, F = 3, R = 2, D = 5, DS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic enq = 0, deq = 0;
  logic [W-1:0] enq_data = '0, deq_data;
  logic enq_rdy, deq_rdy;
  logic s_enq = 0, s_deq = 0;
  logic [W-1:0] s_enq_data = '0, s_deq_data;
  logic s_enq_rdy, s_deq_rdy;

  int checks = 0, fails = 0;
  bit done = 0;

  timed_credit_fifo #(.WIDTH(W), .FWD_LAT(F), .REV_LAT(R), .DEPTH(D)) i_timed_credit_fifo (
    .clk(clk), .rst_n(rst_n), .enq(enq), .enq_data(enq_data), .enq_rdy(enq_rdy),
    .deq(deq), .deq_data(deq_data), .deq_rdy(deq_rdy));

  timed_credit_fifo #(.WIDTH(W), .FWD_LAT(F), .REV_LAT(R), .DEPTH(DS)) i_timed_credit_fifo_shallow (
    .clk(clk), .rst_n(rst_n), .enq(s_enq), .enq_data(s_enq_data), .enq_rdy(s_enq_rdy),
    .deq(s_deq), .deq_data(s_deq_data), .deq_rdy(s_deq_rdy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) step();
    chk(enq_rdy == 1, "R1 enq_rdy", enq_rdy, 1);
    chk(deq_rdy == 0, "R1 deq_rdy", deq_rdy, 0);
    chk(s_enq_rdy == 1 && s_deq_rdy == 0, "R1 shallow", {s_enq_rdy, s_deq_rdy}, 2);
    rst_n = 1;
    step();
  endtask

  task automatic t_latency();
    enq = 1; enq_data = 8'hA5;
    step();
    enq = 0;
    chk(deq_rdy == 0, "R2 early c+1", deq_rdy, 0);
    step();
    chk(deq_rdy == 0, "R2 early c+2", deq_rdy, 0);
    step();
    chk(deq_rdy == 1, "R2 visible c+F", deq_rdy, 1);
    chk(deq_data == 8'hA5, "R2 data", deq_data, 8'hA5);
    deq = 1;
    step();
    deq = 0;
    chk(deq_rdy == 0, "R2 empty after pop", deq_rdy, 0);
    repeat (R + 1) step();
  endtask

  task automatic t_fill_stall();
    for (int i = 0; i < D; i++) begin
      chk(enq_rdy == 1, "R4 credit held", enq_rdy, 1);
      enq = 1; enq_data = W'(8'h10 + i);
      step();
    end
    chk(enq_rdy == 0, "R4 credits exhausted", enq_rdy, 0);
    enq_data = 8'hEE;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(enq_rdy == 0, "R5 stays blocked", enq_rdy, 0);
    end
    enq = 0;
    chk(deq_rdy == 1 && deq_data == 8'h10, "R6 head word", deq_data, 8'h10);
    deq = 1;
    step();
    deq = 0;
    chk(enq_rdy == 0, "R3 credit not yet back d+R-1", enq_rdy, 0);
    step();
    chk(enq_rdy == 1, "R3 credit back d+R", enq_rdy, 1);
    for (int i = 1; i < D; i++) begin
      chk(deq_rdy == 1 && deq_data == W'(8'h10 + i), "R6 order", deq_data, 8'h10 + i);
      deq = 1;
      step();
    end
    deq = 0;
    chk(deq_rdy == 0, "R5 blocked word not delivered", deq_rdy, 0);
    repeat (4) step();
    chk(deq_rdy == 0, "R5 no late word", deq_rdy, 0);
  endtask

  task automatic t_deq_empty();
    deq = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(deq_rdy == 0, "R7 empty", deq_rdy, 0);
    end
    deq = 0;
    enq = 1; enq_data = 8'h3C;
    step();
    enq = 0;
    step();
    step();
    chk(deq_rdy == 1 && deq_data == 8'h3C, "R7 word after empty pops", deq_data, 8'h3C);
    deq = 1;
    step();
    deq = 0;
    chk(deq_rdy == 0, "R7 no underflow", deq_rdy, 0);
    repeat (R + 2) step();
  endtask

  task automatic t_stream();
    int tx = 0, rx = 0, stx = 0, srx = 0;
    int win = 0, swin = 0, drop = 0, oerr = 0, soerr = 0;
    enq = 1; s_enq = 1; deq = 1; s_deq = 1;
    for (int c = 0; c < 125; c++) begin
      if (c == 100) begin enq = 0; s_enq = 0; end
      enq_data = W'(tx);
      s_enq_data = W'(stx);
      if (enq && enq_rdy) begin tx++; if (c >= 20) win++; end
      else if (enq && c >= 20) drop++;
      if (s_enq && s_enq_rdy) begin stx++; if (c >= 20) swin++; end
      if (deq_rdy) begin if (deq_data != W'(rx)) oerr++; rx++; end
      if (s_deq_rdy) begin if (s_deq_data != W'(srx)) soerr++; srx++; end
      step();
    end
    deq = 0; s_deq = 0;
    chk(win == 80, "R9 full-rate window", win, 80);
    chk(swin == 48, "R9 credit-limited window", swin, 48);
    chk(drop == 0, "R8 ready never drops", drop, 0);
    chk(rx == tx && tx == 100, "R6 no loss", rx, tx);
    chk(oerr == 0, "R6 order", oerr, 0);
    chk(srx == stx && stx > 0, "R6 no loss shallow", srx, stx);
    chk(soerr == 0, "R6 order shallow", soerr, 0);
    chk(deq_rdy == 0 && s_deq_rdy == 0, "R10 drained", {deq_rdy, s_deq_rdy}, 0);
  endtask

  initial begin
    step();
    t_reset();
    t_latency();
    t_fill_stall();
    t_deq_empty();
    t_stream();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule